// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a small 8-bit processor core to external memory over a multiplexed bus. The core asks for a code fetch, a data read or a data write, giving a 16-bit address and, for writes, a data byte. The controller then runs one bus cycle. A bus cycle is exactly one machine cycle, and a machine cycle is a fixed number of oscillator clocks (twelve by default). The low address byte and the data byte share one 8-bit port. An address latch strobe lets external logic capture the low address before that port turns over to data. The high address byte has its own port.

Code and data reads use different active-low read strobes. Writes use a separate active-low write strobe. An active-low external-access input decides where code fetches go. When it is high, a fetch produces no bus activity and the core is told to take the byte from on-chip ROM. Data accesses always go to the bus.

The shared port is split into an output byte, an output enable and an input byte, so that the pad ring can build the bidirectional pin. The core sees a busy level and a one-clock done pulse. A new request is taken only when no bus cycle is running.

Top module: `xmb_ctrl`

## Requirements
- R1: While reset is high and after it falls, ale is 0, psen_n, rd_n and wr_n are 1, ad_oe is 0, and busy and done are 0.
- R2: A request is accepted when req_valid is high at a clock edge where busy is low. The accepted request holds busy high for exactly 12 clocks and then pulses done for one clock while busy is low.
- R3: During an external bus cycle, a_hi carries address bits 15..8 in all 12 phases. ale is high in phases 0..2, and ad_out carries address bits 7..0 with ad_oe high during those phases.
- R4: In phase 3, ale is already low, but ad_out still carries the low address byte and ad_oe is still high.
- R5: When req_kind = 0 (code fetch) and ea_n = 0, psen_n is low in phases 5..10 only. ad_oe is low from phase 4 on, and the byte on ad_in at the last low-strobe clock is returned on rdata with done.
- R6: When req_kind = 1 (data read), rd_n is low in phases 5..10 only. rdata holds the ad_in value sampled at the last clock in which rd_n is low.
- R7: When req_kind = 2 (data write), ad_out carries the write byte with ad_oe high in phases 4..11, and wr_n is low in phases 5..10 only. The data is therefore valid one clock before the strobe falls and one clock after it rises.
- R8: A code fetch with ea_n = 1 causes no bus activity: ale stays 0, all strobes stay 1, ad_oe stays 0 and a_hi stays 0. It still takes 12 clocks, rom_fetch pulses together with done, and rdata is left unchanged.
- R9: psen_n, rd_n and wr_n are never low together, and none of them is low while ale is high.
- R10: A request with req_kind = 3 is ignored, and so is any request made while busy is high. Neither starts a bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write, 3 ignored |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| ea_n | input | 1 | Low: code fetches use the external bus |
| busy | output | 1 | Bus cycle in progress |
| done | output | 1 | One-clock pulse at the end of a cycle |
| rom_fetch | output | 1 | With done: fetch was served by on-chip ROM |
| rdata | output | 8 | Byte read from the bus |
| ad_out | output | 8 | Shared low port, driven value |
| ad_oe | output | 1 | Shared low port output enable |
| ad_in | input | 8 | Shared low port, sampled value |
| a_hi | output | 8 | High address port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench steps every phase of every request kind, under both settings of ea_n and at edge addresses such as 0000h and FFFFh. It drives ad_in with the true byte only while a read strobe is low and with its complement otherwise, so a read that samples one clock late returns the complement.

- A controller that releases the shared port together with the falling edge of ale fails the phase-3 address check.
- One that drives the write byte only while wr_n is low fails the phase-4 and phase-11 data checks.
- A decoder that ignores ea_n shows psen_n pulses during on-chip fetches.
- A request made mid-cycle, or a kind-3 request, that slips through shows up as an extra done pulse or a stray wr_n.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  // Request kinds; the fourth encoding is reserved and never accepted.
  typedef enum logic [1:0] {
    XK_CODE = 2'd0,
    XK_DRD  = 2'd1,
    XK_DWR  = 2'd2,
    XK_RSV  = 2'd3
  } xk_t;
endpackage

// File: rtl/xmb_seq.sv
module xmb_seq #(
  parameter int MC_CLKS = 12,
  localparam int PW = $clog2(MC_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [PW-1:0] ph,
  output logic          done,
  output logic          act_nxt,
  output logic [PW-1:0] ph_nxt
);
  localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);

  always_comb begin
    act_nxt = busy;
    ph_nxt  = ph;
    if (!busy) begin
      if (start) begin
        act_nxt = 1'b1;
        ph_nxt  = '0;
      end
    end else if (ph == LAST) begin
      act_nxt = 1'b0;
      ph_nxt  = '0;
    end else begin
      ph_nxt = ph + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      done <= 1'b0;
    end else begin
      busy <= act_nxt;
      ph   <= ph_nxt;
      done <= busy && (ph == LAST);
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ph != LAST) |=> busy);
endmodule

// File: rtl/xmb_pins.sv
module xmb_pins
  import xmb_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int PW = $clog2(MC_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_nxt,
  input  logic [PW-1:0] ph_nxt,
  input  xk_t           kind_n,
  input  logic          ext_n,
  input  logic [AW-1:0] addr_n,
  input  logic [DW-1:0] wdata_n,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic [AW-DW-1:0] a_hi
);
  localparam int ALE_OFF = MC_CLKS / 4;
  localparam int DOUT_ON = ALE_OFF + 1;
  localparam int STB_ON  = ALE_OFF + 2;
  localparam int STB_OFF = MC_CLKS - 1;

  int  p;
  logic stb_win;
  assign p       = int'(ph_nxt);
  assign stb_win = (p >= STB_ON) && (p < STB_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      a_hi   <= '0;
    end else begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      a_hi   <= '0;
      if (act_nxt && ext_n) begin
        a_hi <= addr_n[AW-1:DW];
        if (p < ALE_OFF) ale <= 1'b1;
        if (p < DOUT_ON) begin
          ad_oe  <= 1'b1;
          ad_out <= addr_n[DW-1:0];
        end else if (kind_n == XK_DWR) begin
          ad_oe  <= 1'b1;
          ad_out <= wdata_n;
        end
        if (stb_win) begin
          case (kind_n)
            XK_CODE: psen_n <= 1'b0;
            XK_DRD:  rd_n   <= 1'b0;
            XK_DWR:  wr_n   <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R9
  ale_vs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ad_oe);
  // R7
  wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(ad_oe));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> ad_oe);
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
  import xmb_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             ea_n,
  output logic             busy,
  output logic             done,
  output logic             rom_fetch,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int PW = $clog2(MC_CLKS);
  localparam logic [PW-1:0] LAST     = PW'(MC_CLKS - 1);
  localparam logic [PW-1:0] SAMPLE_P = PW'(MC_CLKS - 2);

  logic          start, act_nxt;
  logic [PW-1:0] ph, ph_nxt;
  xk_t           r_kind, kind_n;
  logic          r_ext, ext_n;
  logic [AW-1:0] r_addr, addr_n;
  logic [DW-1:0] r_wd, wd_n;
  xk_t           req_k;

  assign req_k  = xk_t'(req_kind);
  assign start  = req_valid && !busy && (req_k != XK_RSV);
  assign kind_n = start ? req_k : r_kind;
  assign ext_n  = start ? ((req_k != XK_CODE) || !ea_n) : r_ext;
  assign addr_n = start ? req_addr : r_addr;
  assign wd_n   = start ? req_wdata : r_wd;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_kind <= XK_CODE;
      r_ext  <= 1'b0;
      r_addr <= '0;
      r_wd   <= '0;
    end else begin
      r_kind <= kind_n;
      r_ext  <= ext_n;
      r_addr <= addr_n;
      r_wd   <= wd_n;
    end
  end

  xmb_seq #(.MC_CLKS(MC_CLKS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .ph(ph),
    .done(done), .act_nxt(act_nxt), .ph_nxt(ph_nxt)
  );

  xmb_pins #(.MC_CLKS(MC_CLKS), .AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .act_nxt(act_nxt), .ph_nxt(ph_nxt),
    .kind_n(kind_n), .ext_n(ext_n), .addr_n(addr_n), .wdata_n(wd_n),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .a_hi(a_hi)
  );

  // Capture read data on the last clock the read strobe is low.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rom_fetch <= 1'b0;
    end else begin
      rom_fetch <= busy && (ph == LAST) && !r_ext;
      if (busy && r_ext && (r_kind != XK_DWR) && (ph == SAMPLE_P))
        rdata <= ad_in;
    end
  end

  // R8
  psen_src_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (r_ext && r_kind == XK_CODE));
  // R6
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> busy);
  // R10
  rsv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_kind == 2'd3) |=> !busy);
endmodule

// File: tb/xmb_ctrl_test.sv
module xmb_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic ea_n = 1'b0;
  logic busy, done, rom_fetch, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] rdata, ad_out, a_hi;
  logic [7:0] ad_in = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  xmb_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ea_n(ea_n),
    .busy(busy), .done(done), .rom_fetch(rom_fetch), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_bus(input string tag);
    chk(ale == 1'b0, tag, ale, 0);
    chk({psen_n, rd_n, wr_n} == 3'b111, tag, {psen_n, rd_n, wr_n}, 7);
    chk(ad_oe == 1'b0, tag, ad_oe, 0);
  endtask

  task automatic run_one(input int kind, input logic [15:0] addr,
                         input logic [7:0] wd, input logic ea, input logic [7:0] din);
    bit ext;
    string st;
    ext = (kind != 0) || !ea;
    st = ext ? (kind == 0 ? "R5" : (kind == 1 ? "R6" : "R7")) : "R8";
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = addr;
    req_wdata = wd; ea_n = ea;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bit stb, e_oe;
      logic [7:0] e_ad;
      stb  = ext && k >= 5 && k <= 10;
      e_oe = ext && (k < 4 || kind == 2);
      e_ad = (k < 4) ? addr[7:0] : wd;
      chk(busy == 1'b1 && done == 1'b0, "R2", {busy, done}, 2);
      chk(ale == (ext && k < 3), "R3", ale, int'(ext && k < 3));
      chk(a_hi == (ext ? addr[15:8] : 8'h00), ext ? "R3" : "R8", a_hi,
          ext ? addr[15:8] : 0);
      chk(ad_oe == e_oe, (k == 3) ? "R4" : st, ad_oe, e_oe);
      if (e_oe) chk(ad_out == e_ad, (k == 3) ? "R4" : st, ad_out, e_ad);
      chk(psen_n == !(stb && kind == 0), st, psen_n, !(stb && kind == 0));
      chk(rd_n == !(stb && kind == 1), st, rd_n, !(stb && kind == 1));
      chk(wr_n == !(stb && kind == 2), st, wr_n, !(stb && kind == 2));
      chk($countones({~psen_n, ~rd_n, ~wr_n, ale}) <= 1, "R9",
          {psen_n, rd_n, wr_n, ale}, 0);
      ad_in = (k >= 5 && k <= 10) ? din : ~din;
      @(negedge clk);
    end
    if (ext && kind != 2) last_rd = din;
    chk(done == 1'b1 && busy == 1'b0, "R2", {busy, done}, 1);
    chk(rom_fetch == !ext, "R8", rom_fetch, !ext);
    chk(rdata == last_rd, ext ? st : "R8", rdata, last_rd);
    idle_bus("R2");
    @(negedge clk);
    chk(done == 1'b0 && rom_fetch == 1'b0, "R2", {done, rom_fetch}, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [4];
    addrs[0] = 16'h0000; addrs[1] = 16'hFFFF;
    addrs[2] = 16'h12A5; addrs[3] = 16'h5A3C;
    repeat (3) @(negedge clk);
    // R1 during reset
    idle_bus("R1");
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    idle_bus("R1");
    chk(busy == 1'b0 && done == 1'b0, "R1", {busy, done}, 0);

    for (int e = 0; e < 2; e++)
      for (int kd = 0; kd < 3; kd++)
        for (int a = 0; a < 4; a++)
          run_one(kd, addrs[a], addrs[a][7:0] ^ 8'h5A, 1'(e),
                  addrs[a][15:8] + 8'h11 + 8'(kd));

    // R8: on-chip fetch right after an external read keeps rdata
    run_one(1, 16'hBEEF, 8'h00, 1'b0, 8'hC3);
    run_one(0, 16'h0123, 8'h00, 1'b1, 8'h77);

    // R10: reserved kind is ignored
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd3; req_addr = 16'h4444;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10", {busy, done}, 0);
      idle_bus("R10");
    end
    req_valid = 1'b0;

    // R10: a write request raised mid-cycle is not taken
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; req_addr = 16'h2222; ea_n = 1'b0;
    @(negedge clk);
    req_kind = 2'd2; req_addr = 16'h3333; req_wdata = 8'hAA;
    for (int i = 0; i < 11; i++) begin
      chk(wr_n == 1'b1, "R10", wr_n, 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R10", done, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && wr_n == 1'b1, "R10",
          {busy, done, wr_n}, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule